// File: doc/BRIEF.md
# USB IN Endpoint Controller

This block holds the control and status byte of one device-side USB IN endpoint and answers every IN token handed over by the serial interface engine. Each answer is one of four kinds: a data packet, a NAK, a STALL or a zero-length packet. The block tracks the DATA0/DATA1 toggle. It counts committed packets in a transmit buffer of up to `SLOTS` slots, where two slots are used when double buffering is on and one when it is off. It asks the buffer to drop one packet or to drop all of them, and it raises a one-cycle interrupt for every packet consumed by transmission. The packet storage and the serial encoding sit outside this block.

Firmware reaches the block through a single byte. Bit 0 is the packet-ready commit. Bit 1 is buffer-not-empty and is read only. Bit 2 is a sticky underrun flag. Bit 3 is a self-clearing single-packet flush. Bit 4 is the stall request. Bit 5 is a sticky stall-sent flag. Bit 6 is a write-only toggle reset. Bit 7 always reads 0. Sticky flags clear when 0 is written to them and keep their value when 1 is written.

Tokens arrive on a valid/ready stream. Responses leave on a second valid/ready stream that holds one entry. `tok_ready` stays low while a response waits to be taken and while a data packet is in flight. A packet is in flight from token acceptance until `pkt_done`. A response stays stable until `rsp_ready` takes it. The engine reports the end of each data packet with `pkt_done`, qualified by `pkt_acked`.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, no response is pending and `tok_ready` is 1. Bits 7 and 6 always read 0, and a write of 1 to bit 7 changes nothing.
- R2: Writing 1 to bit 6 sets the data toggle to 0, so the next data response carries `rsp_pid`=0. This write wins over an acknowledge in the same cycle.
- R3: In bulk/interrupt mode, a data packet that ends with `pkt_acked`=1 flips the toggle and frees its slot. A packet that ends with `pkt_acked`=0 stays queued and keeps its toggle for the retry. In ISO mode every data response carries `rsp_pid`=0, and each finished packet is consumed whatever the value of `pkt_acked`.
- R4: `rsp_kind` uses these codes: 0 = DATA, 1 = NAK, 2 = STALL, 3 = ZLP. In bulk/interrupt mode with bit 4 set, every token gets STALL, which takes priority over queued data. In ISO mode bit 4 has no effect.
- R5: When a STALL response is accepted, bit 5 is set, every queued packet is discarded and `fifo_clear` pulses in that same cycle. Bits 0 and 1 then read 0. Bit 5 stays set until 0 is written to it.
- R6: Writing 1 to bit 3 makes bit 3 read 1 until the block discards exactly one queued packet. The discard happens on the first cycle with no packet in flight and is signalled by a one-cycle `fifo_drop`. Bit 0 is cleared in the same step.
- R7: A token answered with NAK (bulk/interrupt) or ZLP (ISO) sets bit 2. Bit 2 clears only when 0 is written to it.
- R8: Bit 1 reads 1 exactly while at least one committed packet is queued.
- R9: Writing 1 to bit 0 commits one packet when bit 0 is clear and a slot is free; otherwise the write is ignored. With double buffering on, bit 0 returns to 0 at once while a slot is still free. Bit 0 clears when a packet is consumed, and a set bit 0 implies bit 1.
- R10: In ISO mode with the ISO-update option on, a newly committed packet is hidden until the next `sof` pulse. While hidden it is not sent (tokens get ZLP) and bit 0 reads 0.
- R11: When `irq_en` is 1, `irq` pulses for one cycle right after each cycle in which a packet is consumed by transmission. It never pulses otherwise.
- R12: At most one response is outstanding. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_kind` and `rsp_pid` hold steady. `tok_ready` is 0 while a response is pending or a data packet is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the status byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current status byte |
| mode_iso | input | 1 | 1 = isochronous endpoint |
| mode_dbuf | input | 1 | 1 = two buffer slots in use |
| mode_iso_upd | input | 1 | 1 = hold ISO packets until next SOF |
| irq_en | input | 1 | Interrupt enable |
| sof | input | 1 | Start-of-frame pulse |
| tok_valid | input | 1 | IN token offered |
| tok_ready | output | 1 | Token accepted when high with tok_valid |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Engine takes the response |
| rsp_kind | output | 2 | Response code (R4) |
| rsp_pid | output | 1 | Data toggle for a DATA response |
| pkt_done | input | 1 | Data packet finished on the bus |
| pkt_acked | input | 1 | Host acknowledged the finished packet |
| fifo_drop | output | 1 | Discard one queued packet |
| fifo_clear | output | 1 | Discard all queued packets |
| irq | output | 1 | Packet-sent interrupt pulse |

## Verification
On every cycle the checker enforces the response-stream rules: the response stays stable under back-pressure and no token is accepted while a response is pending. It also checks that ISO mode never yields STALL, the effect of an accepted STALL on the status byte, the stickiness of underrun, the flush bit reading 1 after its write, that bit 0 implies bit 1, and that every interrupt follows a `pkt_done`. Only the bench scenarios can show the protocol outcomes that depend on history. These are the toggle sequence across acked and retried packets, slot counting with and without double buffering, the hiding of ISO packets until SOF, and the single-packet granularity of flush. The bench sweeps every mode combination against every number of committed packets.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;

  typedef enum logic [1:0] {
    RSP_DATA  = 2'd0,
    RSP_NAK   = 2'd1,
    RSP_STALL = 2'd2,
    RSP_ZLP   = 2'd3
  } rsp_kind_e;

  localparam int REG_W        = 8;
  localparam int B_PRDY       = 0;
  localparam int B_NEMPTY     = 1;
  localparam int B_UNDER      = 2;
  localparam int B_FLUSH      = 3;
  localparam int B_STALL_REQ  = 4;
  localparam int B_STALL_SENT = 5;
  localparam int B_CLR_TGL    = 6;

endpackage

// File: rtl/usb_in_ep_csr.sv
module usb_in_ep_csr
  import usb_in_ep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ev_stall_tx,
  input  logic             ev_underrun,
  input  logic             ev_acked,
  input  logic             flush_go,
  output logic             stall_req,
  output logic             stall_sent,
  output logic             underrun,
  output logic             toggle,
  output logic             flush_pend,
  output logic             commit
);

  assign commit = wr && wdata[B_PRDY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall_req  <= 1'b0;
      stall_sent <= 1'b0;
      underrun   <= 1'b0;
      toggle     <= 1'b0;
      flush_pend <= 1'b0;
    end else begin
      if (wr) stall_req <= wdata[B_STALL_REQ];

      // hardware set beats a software clear in the same cycle
      if (ev_stall_tx)                      stall_sent <= 1'b1;
      else if (wr && !wdata[B_STALL_SENT])  stall_sent <= 1'b0;

      if (ev_underrun)                      underrun <= 1'b1;
      else if (wr && !wdata[B_UNDER])       underrun <= 1'b0;

      if (wr && wdata[B_CLR_TGL])           toggle <= 1'b0;
      else if (ev_acked)                    toggle <= ~toggle;

      if (wr && wdata[B_FLUSH])             flush_pend <= 1'b1;
      else if (flush_go)                    flush_pend <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_in_ep_slots.sv
module usb_in_ep_slots #(
  parameter int SLOTS = 2,
  localparam int CW = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic          sent,
  input  logic          drop,
  input  logic          clear,
  input  logic          dbuf,
  input  logic          hold_en,
  input  logic          sof,
  output logic [CW-1:0] cnt,
  output logic          prdy_vis,
  output logic          nempty,
  output logic          avail
);

  localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic [CW-1:0] cnt_q, cnt_n, lim;
  logic          prdy_q, held_q;
  logic          commit_ok, dec;

  assign lim       = dbuf ? SLOTS_C : ONE_C;
  assign commit_ok = commit && !prdy_q && (cnt_q < lim);
  assign dec       = (sent || drop) && (cnt_q != '0);

  always_comb begin
    cnt_n = cnt_q;
    if (commit_ok) cnt_n = cnt_n + ONE_C;
    if (dec)       cnt_n = cnt_n - ONE_C;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prdy_q <= 1'b0;
      held_q <= 1'b0;
    end else if (clear) begin
      cnt_q  <= '0;
      prdy_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (commit_ok)         prdy_q <= !(dbuf && (cnt_n < SLOTS_C));
      else if (sent || drop) prdy_q <= 1'b0;
      if (commit_ok && hold_en) held_q <= 1'b1;
      else if (sof || drop)     held_q <= 1'b0;
    end
  end

  assign cnt      = cnt_q;
  assign nempty   = (cnt_q != '0);
  assign prdy_vis = prdy_q && !held_q;
  assign avail    = (cnt_q != '0) && !held_q;

endmodule

// File: rtl/usb_in_ep_resp.sv
module usb_in_ep_resp
  import usb_in_ep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tok_valid,
  output logic      tok_ready,
  output logic      rsp_valid,
  input  logic      rsp_ready,
  output rsp_kind_e rsp_kind,
  output logic      rsp_pid,
  input  logic      pkt_done,
  input  logic      pkt_acked,
  input  logic      iso,
  input  logic      stall_req,
  input  logic      avail,
  input  logic      toggle,
  output logic      busy,
  output logic      ev_stall_tx,
  output logic      ev_underrun,
  output logic      ev_sent,
  output logic      ev_acked
);

  rsp_kind_e kind_q, kind_n;
  logic      valid_q, pid_q, busy_q, iso_q;
  logic      tok_fire, done_fire;

  assign tok_ready = !valid_q && !busy_q;
  assign tok_fire  = tok_valid && tok_ready;

  // stall outranks data; an empty endpoint answers by mode
  always_comb begin
    if (!iso && stall_req) kind_n = RSP_STALL;
    else if (avail)        kind_n = RSP_DATA;
    else if (iso)          kind_n = RSP_ZLP;
    else                   kind_n = RSP_NAK;
  end

  assign done_fire   = pkt_done && busy_q && !valid_q;
  assign ev_underrun = tok_fire && ((kind_n == RSP_NAK) || (kind_n == RSP_ZLP));
  assign ev_stall_tx = valid_q && rsp_ready && (kind_q == RSP_STALL);
  assign ev_sent     = done_fire && (iso_q || pkt_acked);
  assign ev_acked    = done_fire && !iso_q && pkt_acked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      kind_q  <= RSP_NAK;
      pid_q   <= 1'b0;
      busy_q  <= 1'b0;
      iso_q   <= 1'b0;
    end else begin
      if (tok_fire) begin
        valid_q <= 1'b1;
        kind_q  <= kind_n;
        pid_q   <= !iso && (kind_n == RSP_DATA) && toggle;
        busy_q  <= (kind_n == RSP_DATA);
        iso_q   <= iso;
      end else begin
        if (valid_q && rsp_ready) valid_q <= 1'b0;
        if (done_fire)            busy_q  <= 1'b0;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_kind  = kind_q;
  assign rsp_pid   = pid_q;
  assign busy      = busy_q;

endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl
  import usb_in_ep_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       mode_iso,
  input  logic       mode_dbuf,
  input  logic       mode_iso_upd,
  input  logic       irq_en,
  input  logic       sof,
  input  logic       tok_valid,
  output logic       tok_ready,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [1:0] rsp_kind,
  output logic       rsp_pid,
  input  logic       pkt_done,
  input  logic       pkt_acked,
  output logic       fifo_drop,
  output logic       fifo_clear,
  output logic       irq
);

  localparam int CW = $clog2(SLOTS + 1);

  logic          stall_req, stall_sent, underrun, toggle, flush_pend, commit;
  logic          ev_stall_tx, ev_underrun, ev_sent, ev_acked, busy, flush_go;
  logic [CW-1:0] cnt;
  logic          prdy_vis, nempty, avail;
  rsp_kind_e     kind;
  logic          irq_q;

  assign flush_go = flush_pend && !busy;

  usb_in_ep_csr csr_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (reg_wr),
    .wdata       (reg_wdata),
    .ev_stall_tx (ev_stall_tx),
    .ev_underrun (ev_underrun),
    .ev_acked    (ev_acked),
    .flush_go    (flush_go),
    .stall_req   (stall_req),
    .stall_sent  (stall_sent),
    .underrun    (underrun),
    .toggle      (toggle),
    .flush_pend  (flush_pend),
    .commit      (commit)
  );

  usb_in_ep_slots #(.SLOTS(SLOTS)) slots_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit),
    .sent     (ev_sent),
    .drop     (flush_go),
    .clear    (ev_stall_tx),
    .dbuf     (mode_dbuf),
    .hold_en  (mode_iso && mode_iso_upd),
    .sof      (sof),
    .cnt      (cnt),
    .prdy_vis (prdy_vis),
    .nempty   (nempty),
    .avail    (avail)
  );

  usb_in_ep_resp resp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tok_valid   (tok_valid),
    .tok_ready   (tok_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_kind    (kind),
    .rsp_pid     (rsp_pid),
    .pkt_done    (pkt_done),
    .pkt_acked   (pkt_acked),
    .iso         (mode_iso),
    .stall_req   (stall_req),
    .avail       (avail),
    .toggle      (toggle),
    .busy        (busy),
    .ev_stall_tx (ev_stall_tx),
    .ev_underrun (ev_underrun),
    .ev_sent     (ev_sent),
    .ev_acked    (ev_acked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ev_sent && irq_en;
  end

  always_comb begin
    reg_rdata               = '0;
    reg_rdata[B_PRDY]       = prdy_vis;
    reg_rdata[B_NEMPTY]     = nempty;
    reg_rdata[B_UNDER]      = underrun;
    reg_rdata[B_FLUSH]      = flush_pend;
    reg_rdata[B_STALL_REQ]  = stall_req;
    reg_rdata[B_STALL_SENT] = stall_sent;
  end

  assign rsp_kind   = kind;
  assign fifo_drop  = flush_go;
  assign fifo_clear = ev_stall_tx;
  assign irq        = irq_q;

  logic unused_cnt;
  assign unused_cnt = ^cnt;

endmodule

// File: rtl/usb_in_ep_ctrl_chk.sv
module usb_in_ep_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       mode_iso,
  input logic       tok_ready,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_kind,
  input logic       rsp_pid,
  input logic       pkt_done,
  input logic       irq
);

  p_hi_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[7:6] == 2'b00);

  p_iso_no_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rsp_valid) && $past(mode_iso)) |-> (rsp_kind != 2'd2));

  p_stall_effect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_kind == 2'd2) |=>
      (reg_rdata[5] && !reg_rdata[1] && !reg_rdata[0]));

  p_flush_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[3]) |=> reg_rdata[3]);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[2] && !(reg_wr && !reg_wdata[2])) |=> reg_rdata[2]);

  p_prdy_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[0] |-> reg_rdata[1]);

  p_irq_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pkt_done));

  p_rsp_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_kind) && $stable(rsp_pid)));

  p_one_outstanding_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !tok_ready);

endmodule

bind usb_in_ep_ctrl usb_in_ep_ctrl_chk chk_i (.*);

// File: tb/usb_in_ep_ctrl_tb_top.sv
module usb_in_ep_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       mode_iso, mode_dbuf, mode_iso_upd, irq_en, sof;
  logic       tok_valid, tok_ready, rsp_valid, rsp_ready;
  logic [1:0] rsp_kind;
  logic       rsp_pid, pkt_done, pkt_acked, fifo_drop, fifo_clear, irq;

  int checks = 0;
  int fails  = 0;

  localparam logic [1:0] K_DATA = 2'd0, K_NAK = 2'd1, K_STALL = 2'd2, K_ZLP = 2'd3;

  always #4 clk = ~clk;

  usb_in_ep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mode_iso(mode_iso), .mode_dbuf(mode_dbuf),
    .mode_iso_upd(mode_iso_upd), .irq_en(irq_en), .sof(sof),
    .tok_valid(tok_valid), .tok_ready(tok_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_pid(rsp_pid),
    .pkt_done(pkt_done), .pkt_acked(pkt_acked), .fifo_drop(fifo_drop),
    .fifo_clear(fifo_clear), .irq(irq)
  );

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 0; reg_wdata = 0; sof = 0;
    tok_valid = 0; rsp_ready = 0; pkt_done = 0; pkt_acked = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic pulse_sof();
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
  endtask

  // token in, response checked, then taken after wait_n held cycles
  task automatic token(input logic [1:0] ek, input logic ep, input int wait_n, input string req);
    check({req, " R12 tok_ready idle"}, tok_ready, 1);
    tok_valid = 1'b1;
    @(negedge clk);
    tok_valid = 1'b0;
    check({req, " R12 rsp_valid"}, rsp_valid, 1);
    check({req, " R4 kind/pid"}, {rsp_kind, rsp_pid}, {ek, ep});
    for (int i = 0; i < wait_n; i++) begin
      @(negedge clk);
      check({req, " R12 held under back-pressure"}, {rsp_valid, rsp_kind, rsp_pid}, {1'b1, ek, ep});
      check({req, " R12 tok_ready low"}, tok_ready, 0);
    end
    rsp_ready = 1'b1;
    #1;
    check({req, " R5 fifo_clear"}, fifo_clear, (ek == K_STALL));
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic done(input logic ack, input logic exp_irq, input string req);
    pkt_done = 1'b1; pkt_acked = ack;
    @(negedge clk);
    pkt_done = 1'b0; pkt_acked = 1'b0;
    check({req, " R11 irq"}, irq, exp_irq);
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    mode_iso = 0; mode_dbuf = 0; mode_iso_upd = 0; irq_en = 1;
    do_reset();

    // R1 reset state and dead bits
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset tok_ready", tok_ready, 1);
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset irq", irq, 0);
    wr(8'h80); check("R1 bit7 ignored", reg_rdata, 8'h00);
    wr(8'h40); check("R1 bit6 reads 0", reg_rdata, 8'h00);

    // sweep: every mode combination against 0..2 commits
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 3; k++) begin
        int lim, c; logic h, av; logic [7:0] e;
        mode_iso = m[0]; mode_dbuf = m[1]; mode_iso_upd = m[2];
        do_reset();
        lim = mode_dbuf ? 2 : 1;
        c   = (k < lim) ? k : lim;
        h   = mode_iso && mode_iso_upd && (c > 0);
        for (int j = 0; j < k; j++) wr(8'h01);
        e = {6'b0, (c > 0), ((c > 0) && (c == lim) && !h)};
        check("R8 R9 R10 sweep after commits", reg_rdata, e);
        av = (c > 0) && !h;
        token(av ? K_DATA : (mode_iso ? K_ZLP : K_NAK), 1'b0, m % 2, "R3 R10 sweep first");
        if (!av) check("R7 sweep underrun", reg_rdata[2], 1);
        if (h) begin
          pulse_sof();
          token(K_DATA, 1'b0, 0, "R10 sweep after sof");
        end
        if (c > 0) begin
          done(1'b1, 1'b1, "R11 sweep first sent");
          e = {5'b0, !av, (c > 1), 1'b0};
          check("R8 R9 sweep after first send", reg_rdata, e);
          if (c > 1) begin
            token(K_DATA, !mode_iso, 0, "R3 sweep second");
            done(1'b1, 1'b1, "R11 sweep second sent");
            check("R8 sweep drained", reg_rdata[1], 0);
          end
        end
      end
    end

    // R3 R2 toggle sequence in bulk mode
    mode_iso = 0; mode_dbuf = 0; mode_iso_upd = 0;
    do_reset();
    wr(8'h01); token(K_DATA, 1'b0, 0, "R3 first");
    done(1'b1, 1'b1, "R3 first acked");
    wr(8'h01); token(K_DATA, 1'b1, 0, "R3 second");
    check("R12 busy blocks tokens", tok_ready, 0);
    done(1'b0, 1'b0, "R3 not acked");
    check("R3 packet retained", reg_rdata, 8'h03);
    token(K_DATA, 1'b1, 0, "R3 retry keeps toggle");
    done(1'b1, 1'b1, "R3 retry acked");
    wr(8'h01); token(K_DATA, 1'b0, 0, "R3 toggle wrapped");
    done(1'b1, 1'b1, "R3 third acked");
    wr(8'h40); wr(8'h01);
    token(K_DATA, 1'b0, 0, "R2 toggle cleared");
    irq_en = 0;
    done(1'b1, 1'b0, "R11 disabled irq");
    irq_en = 1;

    // R6 single-packet flush with double buffering
    mode_dbuf = 1;
    do_reset();
    wr(8'h01); wr(8'h01);
    check("R9 two slots full", reg_rdata, 8'h03);
    wr(8'h01);
    check("R9 commit ignored when full", reg_rdata, 8'h03);
    wr(8'h08);
    check("R6 flush pending", reg_rdata, 8'h0B);
    check("R6 fifo_drop pulse", fifo_drop, 1);
    @(negedge clk);
    check("R6 one packet dropped", reg_rdata, 8'h02);
    check("R6 fifo_drop ends", fifo_drop, 0);
    wr(8'h08);
    @(negedge clk);
    check("R6 R8 second flush empties", reg_rdata, 8'h00);

    // R5 R4 R7 stall and sticky flags in bulk mode
    mode_dbuf = 0;
    do_reset();
    wr(8'h01); wr(8'h11);
    check("R4 stall requested", reg_rdata, 8'h13);
    token(K_STALL, 1'b0, 2, "R4 stall beats data");
    check("R5 stall sent flushes", reg_rdata, 8'h30);
    wr(8'h30);
    check("R5 write 1 keeps sticky", reg_rdata, 8'h30);
    wr(8'h10);
    check("R5 write 0 clears sticky", reg_rdata, 8'h10);
    wr(8'h00);
    token(K_NAK, 1'b0, 0, "R7 nak");
    check("R7 underrun set", reg_rdata, 8'h04);
    wr(8'h04);
    check("R7 write 1 keeps underrun", reg_rdata, 8'h04);
    wr(8'h00);
    check("R7 write 0 clears underrun", reg_rdata, 8'h00);

    // R4 stall request ignored in ISO mode
    mode_iso = 1;
    do_reset();
    wr(8'h10);
    token(K_ZLP, 1'b0, 0, "R4 iso ignores stall");
    check("R4 R7 iso status", reg_rdata, 8'h14);
    wr(8'h11);
    token(K_DATA, 1'b0, 0, "R4 iso sends data despite stall");
    done(1'b0, 1'b1, "R3 iso consumed without ack");
    check("R3 iso slot freed", reg_rdata[1], 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule